// File: doc/BRIEF.md
# Triplex Word Voter with Degrade-to-Simplex

This block sits behind three copies of the same functional unit and merges their W-bit results into one word. It does not vote bit by bit. It compares the first two words as wholes and forwards one complete input word. If the first two agree, it forwards the first. If they differ, it forwards the third. As a result, the forwarded word is always exactly one of the three inputs and never a blend of bits from different inputs.

A comparison stage also classifies every presented triple. All three words may agree. Exactly two may agree, which marks the odd one out as faulty. Or no two may agree. When a valid triple shows exactly two in agreement, the controller leaves triplex operation. It retires the faulty copy and one of the healthy copies, and from the next cycle it passes the remaining unit straight through. A triple in which all three differ raises its own flag and leaves the configuration untouched. Only reset restores triplex operation.

Top module: `tmr_word_voter`

## Requirements
- R1: In triplex mode, `voted` equals `word_a` when `word_a` equals `word_b`, and equals `word_c` otherwise. This includes the case where all three words differ.
- R2: `disagree` is 1 exactly when `in_valid` is 1 and `word_a` differs from `word_b`. This holds in either mode and is combinational.
- R3: `voted` always equals at least one of `word_a`, `word_b` or `word_c` in full, bit for bit.
- R4: `all_differ` is 1 exactly when `in_valid` is 1 and no two of the three words are equal. Such a triple does not change the mode or the survivor.
- R5: In triplex mode, a valid triple in which exactly two words are equal switches the block to simplex after that clock edge. The survivor becomes the lower-indexed member of the equal pair, with unit codes a=0, b=1, c=2. So a pair a,b gives 0, a pair a,c gives 0, and a pair b,c gives 1.
- R6: In simplex mode, `voted` equals the survivor's word whatever the other two words are. Later valid triples, including ones with a new single mismatch, leave the mode and the survivor unchanged.
- R7: The mode and the survivor change only at a clock edge where `in_valid` is 1. A mismatching triple presented with `in_valid` at 0 has no effect.
- R8: A synchronous active-high reset puts the block in triplex mode. In triplex mode `simplex_mode` reads 0 and `survivor` reads 3, which means no survivor. In simplex mode `simplex_mode` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The three words form a valid triple this cycle |
| word_a | input | W | Output of replica 0 |
| word_b | input | W | Output of replica 1 |
| word_c | input | W | Output of replica 2 |
| voted | output | W | Forwarded word |
| disagree | output | 1 | Replicas 0 and 1 differ on a valid triple |
| all_differ | output | 1 | No two replicas agree on a valid triple |
| simplex_mode | output | 1 | 1 after degradation to a single unit |
| survivor | output | 2 | Unit code of the retained replica, 3 while in triplex |

## Verification
A wrong stored mode or survivor shows up on the very next presented triple. `voted` follows a single input while it should still apply the compare rule, or it follows the wrong replica, and `simplex_mode` and `survivor` give the same error away directly. An update made on the wrong edge shows one cycle later. Examples are a switch taken while `in_valid` was low, a switch on a triple where all three differ, and a second switch after degradation. The bench therefore checks every output on every cycle against a model of the state that it keeps itself. It covers each possible faulty replica, and each case starts from a fresh reset.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

    typedef enum logic {
        MODE_TRIPLEX = 1'b0,
        MODE_SIMPLEX = 1'b1
    } mode_e;

    typedef logic [1:0] unit_t;

    localparam unit_t UNIT_A    = 2'd0;
    localparam unit_t UNIT_B    = 2'd1;
    localparam unit_t UNIT_C    = 2'd2;
    localparam unit_t UNIT_NONE = 2'd3;

    localparam int NUM_UNITS = 3;
    localparam int NUM_PAIRS = 3;

    // pair index 0: a-b, 1: b-c, 2: a-c
    typedef struct packed {
        logic eq_ac;
        logic eq_bc;
        logic eq_ab;
    } match_t;

    typedef struct packed {
        logic  single_fault;
        logic  no_agreement;
        unit_t keeper;
    } verdict_t;

    function automatic int pair_lo(input int p);
        return (p == 1) ? 1 : 0;
    endfunction

    function automatic int pair_hi(input int p);
        return (p == 0) ? 1 : 2;
    endfunction

    function automatic verdict_t classify(input match_t m);
        verdict_t v;
        int n;
        n = int'(m.eq_ab) + int'(m.eq_bc) + int'(m.eq_ac);
        v.single_fault = (n == 1);
        v.no_agreement = (n == 0);
        if (m.eq_ab || m.eq_ac)
            v.keeper = UNIT_A;
        else if (m.eq_bc)
            v.keeper = UNIT_B;
        else
            v.keeper = UNIT_NONE;
        return v;
    endfunction

endpackage

// File: rtl/tmr_pair_cmp.sv
module tmr_pair_cmp
    import tmr_vote_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [NUM_UNITS-1:0][W-1:0] words,
    output match_t                      match
);
    logic [NUM_PAIRS-1:0] eq;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = pair_lo(p);
        localparam int HI = pair_hi(p);
        assign eq[p] = (words[LO] == words[HI]);
    end

    assign match.eq_ab = eq[0];
    assign match.eq_bc = eq[1];
    assign match.eq_ac = eq[2];
endmodule

// File: rtl/tmr_reconfig.sv
module tmr_reconfig
    import tmr_vote_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  verdict_t verdict,
    output mode_e    mode,
    output unit_t    keeper
);
    mode_e mode_q;
    unit_t keeper_q;
    logic  degrade;

    assign degrade = in_valid && (mode_q == MODE_TRIPLEX) && verdict.single_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_TRIPLEX;
            keeper_q <= UNIT_NONE;
        end else if (degrade) begin
            mode_q   <= MODE_SIMPLEX;
            keeper_q <= verdict.keeper;
        end
    end

    assign mode   = mode_q;
    assign keeper = keeper_q;
endmodule

// File: rtl/tmr_word_mux.sv
module tmr_word_mux
    import tmr_vote_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [NUM_UNITS-1:0][W-1:0] words,
    input  match_t                      match,
    input  mode_e                       mode,
    input  unit_t                       keeper,
    output logic [W-1:0]                voted
);
    logic [W-1:0] tmr_pick;
    logic [W-1:0] solo_pick;

    assign tmr_pick = match.eq_ab ? words[UNIT_A] : words[UNIT_C];

    always_comb begin
        case (keeper)
            UNIT_B:  solo_pick = words[UNIT_B];
            UNIT_C:  solo_pick = words[UNIT_C];
            default: solo_pick = words[UNIT_A];
        endcase
    end

    assign voted = (mode == MODE_SIMPLEX) ? solo_pick : tmr_pick;
endmodule

// File: rtl/tmr_word_voter.sv
module tmr_word_voter
    import tmr_vote_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    input  logic [W-1:0] word_c,
    output logic [W-1:0] voted,
    output logic         disagree,
    output logic         all_differ,
    output logic         simplex_mode,
    output logic [1:0]   survivor
);
    logic [NUM_UNITS-1:0][W-1:0] words;
    match_t   match;
    verdict_t verdict;
    mode_e    mode;
    unit_t    keeper;

    assign words = {word_c, word_b, word_a};

    tmr_pair_cmp #(.W(W)) u_cmp (
        .words (words),
        .match (match)
    );

    assign verdict = classify(match);

    tmr_reconfig u_cfg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .verdict  (verdict),
        .mode     (mode),
        .keeper   (keeper)
    );

    tmr_word_mux #(.W(W)) u_mux (
        .words  (words),
        .match  (match),
        .mode   (mode),
        .keeper (keeper),
        .voted  (voted)
    );

    assign disagree     = in_valid && !match.eq_ab;
    assign all_differ   = in_valid && verdict.no_agreement;
    assign simplex_mode = (mode == MODE_SIMPLEX);
    assign survivor     = keeper;
endmodule

// File: rtl/tmr_word_voter_chk.sv
module tmr_word_voter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] word_a,
    input logic [W-1:0] word_b,
    input logic [W-1:0] word_c,
    input logic [W-1:0] voted,
    input logic         disagree,
    input logic         all_differ,
    input logic         simplex_mode,
    input logic [1:0]   survivor
);
    assert_disagree_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (word_a != word_b)) |-> disagree);

    assert_whole_word_R3: assert property (@(posedge clk) disable iff (rst)
        (voted == word_a) || (voted == word_b) || (voted == word_c));

    assert_triplex_pick_R1: assert property (@(posedge clk) disable iff (rst)
        (!simplex_mode && (word_a == word_b)) |-> (voted == word_a));

    assert_no_switch_on_chaos_R4: assert property (@(posedge clk) disable iff (rst)
        (!simplex_mode && all_differ) |=> !simplex_mode);

    assert_simplex_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        simplex_mode |=> (simplex_mode && $stable(survivor)));

    assert_simplex_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (simplex_mode && (survivor == 2'd1)) |-> (voted == word_b));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(simplex_mode) && $stable(survivor)));

    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) |-> (!simplex_mode && (survivor == 2'd3)));
endmodule

bind tmr_word_voter tmr_word_voter_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .word_a       (word_a),
    .word_b       (word_b),
    .word_c       (word_c),
    .voted        (voted),
    .disagree     (disagree),
    .all_differ   (all_differ),
    .simplex_mode (simplex_mode),
    .survivor     (survivor)
);

// File: tb/tmr_word_voter_tb.sv
module tmr_word_voter_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] word_a = '0, word_b = '0, word_c = '0;
    logic [W-1:0] voted;
    logic         disagree, all_differ, simplex_mode;
    logic [1:0]   survivor;

    always #10 clk = ~clk;

    tmr_word_voter #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .word_a(word_a), .word_b(word_b), .word_c(word_c),
        .voted(voted), .disagree(disagree), .all_differ(all_differ),
        .simplex_mode(simplex_mode), .survivor(survivor)
    );

    typedef struct {
        logic [W-1:0] voted;
        logic         disagree;
        logic         all_differ;
        logic         simplex;
        logic [1:0]   surv;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    event ev_go;
    int   total = 0;
    int   bad = 0;
    logic m_simplex = 1'b0;
    logic [1:0] m_surv = 2'd3;
    logic done = 1'b0;

    task automatic chk(input bit ok, input string what, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: applies one triple, predicts outputs, advances the model
    task automatic drive(input logic v, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] c,
                         input string tag);
        exp_t e;
        int n;
        @(negedge clk);
        in_valid = v; word_a = a; word_b = b; word_c = c;
        n = int'(a == b) + int'(b == c) + int'(a == c);
        if (m_simplex)
            e.voted = (m_surv == 2'd1) ? b : (m_surv == 2'd2) ? c : a;
        else
            e.voted = (a == b) ? a : c;
        e.disagree   = v && (a != b);
        e.all_differ = v && (n == 0);
        e.simplex    = m_simplex;
        e.surv       = m_surv;
        e.tag        = tag;
        exp_q.push_back(e);
        -> ev_go;
        if (v && !m_simplex && n == 1) begin
            m_simplex = 1'b1;
            m_surv    = ((a == b) || (a == c)) ? 2'd0 : 2'd1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_simplex = 1'b0;
        m_surv = 2'd3;
    endtask

    // monitor: pops predictions and compares, away from the clock edge
    initial begin
        forever begin
            @(ev_go);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(voted == e.voted, "voted (R1 R3 R6)", e.tag, voted, e.voted);
                chk(disagree == e.disagree, "disagree R2", e.tag,
                    W'(disagree), W'(e.disagree));
                chk(all_differ == e.all_differ, "all_differ R4", e.tag,
                    W'(all_differ), W'(e.all_differ));
                chk(simplex_mode == e.simplex, "simplex_mode (R5 R7 R8)", e.tag,
                    W'(simplex_mode), W'(e.simplex));
                chk(survivor == e.surv, "survivor (R5 R6 R8)", e.tag,
                    W'(survivor), W'(e.surv));
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        drive(1'b0, 16'h1111, 16'h1111, 16'h1111, "R8 reset state");
        drive(1'b1, 16'hA5A5, 16'hA5A5, 16'hA5A5, "R1 all agree");
        drive(1'b1, 16'h0F0F, 16'h0F0F, 16'h0F0F, "R1 all agree 2");
        drive(1'b0, 16'h1234, 16'h9999, 16'h1234, "R7 invalid mismatch");
        drive(1'b1, 16'h7777, 16'h7777, 16'h7777, "R7 mode held after idle");
        drive(1'b1, 16'h00FF, 16'hFF00, 16'h0F0F, "R4 all differ");
        drive(1'b1, 16'h1357, 16'h2468, 16'hFFFF, "R4 all differ 2");
        drive(1'b1, 16'h4444, 16'h4444, 16'h4444, "R4 no reconfig after chaos");
        // replica a faulty: b,c agree -> survivor 1
        drive(1'b1, 16'hDEAD, 16'hBEEF, 16'hBEEF, "R5 a faulty");
        drive(1'b1, 16'h0001, 16'h0002, 16'h0003, "R6 follow b");
        drive(1'b1, 16'h5555, 16'hAAAA, 16'h5555, "R6 second fault ignored");
        drive(1'b0, 16'h1111, 16'h2222, 16'h2222, "R6 idle in simplex");
        // replica b faulty
        do_reset();
        drive(1'b0, 16'h0000, 16'h0000, 16'h0000, "R8 reset after simplex");
        drive(1'b1, 16'hC0DE, 16'h0BAD, 16'hC0DE, "R5 b faulty, R1 pick c");
        drive(1'b1, 16'h1010, 16'h2020, 16'h2020, "R6 follow a");
        drive(1'b1, 16'h3030, 16'h3030, 16'h4040, "R6 follow a 2");
        // replica c faulty
        do_reset();
        drive(1'b1, 16'h6060, 16'h6060, 16'h6161, "R5 c faulty");
        drive(1'b1, 16'h8000, 16'h8001, 16'h8001, "R6 follow a despite b,c");
        drive(1'b1, 16'hFFFF, 16'h0000, 16'h1234, "R6 R4 chaos in simplex");
        drive(1'b0, 16'h0000, 16'h0000, 16'h0000, "R6 final");
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule